// File: doc/BRIEF.md
# Multi-stop edge-selectable interval timer

The block measures time intervals in system-clock ticks. One common start input restarts a free-running count, and each of 32 stop inputs then records the count at which its own selected edge arrives. The stop inputs are grouped as four banks of eight. Every stop channel has its own enable and its own edge polarity, and so has the start input. A stop is accepted only after a short hold-off that follows the start edge and only until the measurement window ends. After that the count saturates and a done status bit is set.

Each channel keeps the first qualifying edge it sees after a start. When it does, a per-channel valid flag is raised. All inputs are asynchronous and pass through two-flop synchronisers before edge detection. Configuration and results are reached through a byte-wide register file with an address, write-data, write-strobe and read-data port. Reads are combinational. Writes take effect on the clock edge that samples the strobe.

Top module: `multistop_timer`

## Requirements
- R1: After reset every register address reads 0x00: control, enables, polarities, valid flags, status and all timestamp bytes.
- R2: Control register (address 0) bit 0 picks the start edge: 0 means rising and 1 means falling. A start edge of the selected polarity restarts the count from zero, sets running, clears done and clears every valid flag and timestamp, even when a measurement is already running. An edge of the opposite polarity has no effect.
- R3: A stop edge that arrives d clock cycles after the start edge records a timestamp of d-1. Both edges act on the third rising clock edge after the input changes.
- R4: Hold-off: a stop whose timestamp would be below 4 (d of 4 or less) is ignored. With d = 5 the channel records timestamp 4.
- R5: A channel records only its first qualifying stop edge after a start. Later edges on that channel leave its flag and timestamp unchanged.
- R6: Stop enable for bank b is at address 1+b, with bit i covering channel 8b+i. An edge on a disabled channel is not recorded.
- R7: Stop polarity for bank b is at address 5+b, with bit i for channel 8b+i: 0 means rising and 1 means falling. Only the selected edge is recorded.
- R8: Window: timestamp 9399 is the last one accepted (d = 9400), so a stop with d = 9401 or later is ignored. At the window end done sets and running clears. Stops that arrive while not running are ignored.
- R9: Writing control with bit 7 set clears all valid flags, timestamps and done, in the same edge that takes the write. It does not stop a running count. Bit 7 always reads 0.
- R10: Readback uses these addresses:
  - Valid flags for bank b are at address 9+b.
  - Status is at address 13: bit 0 is done and bit 1 is running.
  - The timestamp of channel c has its low byte at 16+2c and its high byte at 17+2c. In the high byte, bits 5:0 hold timestamp bits 13:8 and bits 7:6 read 0.
  - Unmapped addresses read 0, and writes to read-only addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_in | input | 1 | Common start input, asynchronous |
| stop_in | input | 32 | Stop inputs, bank b on bits 8b+7..8b, asynchronous |
| bus_addr | input | 7 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rdata | output | 8 | Register read data for bus_addr, combinational |

## Verification
An input change takes effect on the third rising edge after it is driven: two synchroniser flops, then the registered result of edge detection. A register write is visible in readback one edge after the strobe, and a read returns in the same cycle as its address. The bench drives inputs just after the falling edge and keeps a behavioural model that it advances on every rising edge. It compares the read data for the current address on every falling edge, so each result is checked in the cycle it is due. On top of that, explicit reads compare fixed expected values taken from the requirements, such as timestamps 9, 4, 19, 39, 299 and 9399, and flags at the hold-off and window boundaries.

// File: rtl/mst_pkg.sv
package mst_pkg;
    localparam int CTRL_ADDR     = 0;
    localparam int CTRL_POL_BIT  = 0;
    localparam int CTRL_CLR_BIT  = 7;
    localparam int STAT_DONE_BIT = 0;
    localparam int STAT_RUN_BIT  = 1;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_sel_e;
endpackage

// File: rtl/mst_edge_sync.sv
module mst_edge_sync #(
    parameter int W      = 33,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    input  logic [W-1:0] pol,
    output logic [W-1:0] ev
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
        logic [W-1:0]             prev;
    } sync_st_t;

    sync_st_t s_d, s_q;
    logic [W-1:0] now_v;

    always_comb begin
        s_d          = s_q;
        s_d.chain[0] = raw;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
        s_d.prev = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign now_v = s_q.chain[STAGES-1];

    for (genvar g = 0; g < W; g++) begin : g_edge
        assign ev[g] = (pol[g] == mst_pkg::EDGE_FALL) ? (~now_v[g] & s_q.prev[g])
                                                      : (now_v[g] & ~s_q.prev[g]);
    end
endmodule

// File: rtl/mst_core.sv
module mst_core #(
    parameter int NCH     = 32,
    parameter int CNT_W   = 14,
    parameter int HOLDOFF = 4,
    parameter int WINDOW  = 9400
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_ev,
    input  logic                      clr,
    input  logic [NCH-1:0]            stop_ev,
    input  logic [NCH-1:0]            stop_en,
    output logic [NCH-1:0]            valid,
    output logic [NCH-1:0][CNT_W-1:0] ts,
    output logic                      done,
    output logic                      running
);
    localparam logic [CNT_W-1:0] HOLD_C = CNT_W'(HOLDOFF);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(WINDOW - 1);
    localparam logic [CNT_W-1:0] END_C  = CNT_W'(WINDOW);

    typedef struct packed {
        logic [CNT_W-1:0]            cnt;
        logic                        run;
        logic                        done;
        logic [NCH-1:0]              valid;
        logic [NCH-1:0][CNT_W-1:0]   ts;
    } core_st_t;

    core_st_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (start_ev) begin
            c_d.cnt   = '0;
            c_d.run   = 1'b1;
            c_d.done  = 1'b0;
            c_d.valid = '0;
            c_d.ts    = '0;
        end else begin
            if (c_q.run) begin
                for (int i = 0; i < NCH; i++) begin
                    if (stop_ev[i] && stop_en[i] && !c_q.valid[i] && (c_q.cnt >= HOLD_C)) begin
                        c_d.valid[i] = 1'b1;
                        c_d.ts[i]    = c_q.cnt;
                    end
                end
                if (c_q.cnt >= LAST_C) begin
                    c_d.cnt  = END_C;
                    c_d.run  = 1'b0;
                    c_d.done = 1'b1;
                end else begin
                    c_d.cnt = c_q.cnt + CNT_W'(1);
                end
            end
            if (clr) begin
                c_d.valid = '0;
                c_d.ts    = '0;
                c_d.done  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign valid   = c_q.valid;
    assign ts      = c_q.ts;
    assign done    = c_q.done;
    assign running = c_q.run;
endmodule

// File: rtl/multistop_timer.sv
module multistop_timer
    import mst_pkg::*;
#(
    parameter int NUM_BANKS   = 4,
    parameter int BANK_W      = 8,
    parameter int CNT_W       = 14,
    parameter int HOLDOFF     = 4,
    parameter int WINDOW      = 9400,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_in,
    input  logic [NUM_BANKS*BANK_W-1:0] stop_in,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [7:0]                  bus_wdata,
    input  logic                        bus_we,
    output logic [7:0]                  bus_rdata
);
    localparam int NCH       = NUM_BANKS * BANK_W;
    localparam int EN_BASE   = CTRL_ADDR + 1;
    localparam int POL_BASE  = EN_BASE + NUM_BANKS;
    localparam int VAL_BASE  = POL_BASE + NUM_BANKS;
    localparam int STAT_ADDR = VAL_BASE + NUM_BANKS;
    localparam int TS_BASE   = 1 << $clog2(STAT_ADDR + 1);

    typedef struct packed {
        logic           start_pol;
        logic [NCH-1:0] en;
        logic [NCH-1:0] pol;
    } cfg_t;

    cfg_t                      cfg_d, cfg_q;
    logic                      clr;
    logic                      start_ev;
    logic [NCH-1:0]            stop_ev;
    logic [NCH-1:0]            valid;
    logic [NCH-1:0][CNT_W-1:0] ts;
    logic                      done;
    logic                      running;

    mst_edge_sync #(.W(NCH + 1), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({start_in, stop_in}),
        .pol   ({cfg_q.start_pol, cfg_q.pol}),
        .ev    ({start_ev, stop_ev})
    );

    mst_core #(.NCH(NCH), .CNT_W(CNT_W), .HOLDOFF(HOLDOFF), .WINDOW(WINDOW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_ev (start_ev),
        .clr      (clr),
        .stop_ev  (stop_ev),
        .stop_en  (cfg_q.en),
        .valid    (valid),
        .ts       (ts),
        .done     (done),
        .running  (running)
    );

    always_comb begin
        cfg_d = cfg_q;
        clr   = 1'b0;
        if (bus_we) begin
            if (bus_addr == ADDR_W'(CTRL_ADDR)) begin
                cfg_d.start_pol = bus_wdata[CTRL_POL_BIT];
                clr             = bus_wdata[CTRL_CLR_BIT];
            end
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (bus_addr == ADDR_W'(EN_BASE + b))
                    cfg_d.en[b*BANK_W +: BANK_W] = bus_wdata[BANK_W-1:0];
                if (bus_addr == ADDR_W'(POL_BASE + b))
                    cfg_d.pol[b*BANK_W +: BANK_W] = bus_wdata[BANK_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        logic [15:0] ts_w;
        bus_rdata = '0;
        ts_w      = '0;
        if (bus_addr == ADDR_W'(CTRL_ADDR))
            bus_rdata[CTRL_POL_BIT] = cfg_q.start_pol;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_addr == ADDR_W'(EN_BASE + b))
                bus_rdata[BANK_W-1:0] = cfg_q.en[b*BANK_W +: BANK_W];
            if (bus_addr == ADDR_W'(POL_BASE + b))
                bus_rdata[BANK_W-1:0] = cfg_q.pol[b*BANK_W +: BANK_W];
            if (bus_addr == ADDR_W'(VAL_BASE + b))
                bus_rdata[BANK_W-1:0] = valid[b*BANK_W +: BANK_W];
        end
        if (bus_addr == ADDR_W'(STAT_ADDR)) begin
            bus_rdata[STAT_DONE_BIT] = done;
            bus_rdata[STAT_RUN_BIT]  = running;
        end
        for (int c = 0; c < NCH; c++) begin
            ts_w = 16'(ts[c]);
            if (bus_addr == ADDR_W'(TS_BASE + 2*c))     bus_rdata = ts_w[7:0];
            if (bus_addr == ADDR_W'(TS_BASE + 2*c + 1)) bus_rdata = ts_w[15:8];
        end
    end
endmodule

// File: rtl/mst_timer_chk.sv
module mst_timer_chk #(
    parameter int NCH     = 32,
    parameter int CNT_W   = 14,
    parameter int HOLDOFF = 4,
    parameter int WINDOW  = 9400
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      start_ev,
    input logic                      clr,
    input logic [NCH-1:0]            valid,
    input logic [NCH-1:0][CNT_W-1:0] ts,
    input logic                      done,
    input logic                      running
);
    localparam logic [CNT_W-1:0] HOLD_C = CNT_W'(HOLDOFF);
    localparam logic [CNT_W-1:0] END_C  = CNT_W'(WINDOW);

    // R8: a finished window is never still counting
    a_r8_done_not_running: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !running);

    // R2: a start edge restarts the measurement
    a_r2_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (running && !done && (valid == '0)));

    // R9: the clear command empties flags and done
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((valid == '0) && !done));

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        // R4: no capture before the hold-off
        a_r4_after_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(valid[g]) |-> (ts[g] >= HOLD_C));

        // R8: no capture past the window
        a_r8_inside_window: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(valid[g]) |-> (ts[g] < END_C));

        // R5: a captured timestamp stays until start or clear
        a_r5_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (valid[g] && !start_ev && !clr) |=> (valid[g] && $stable(ts[g])));
    end
endmodule

bind multistop_timer mst_timer_chk #(
    .NCH(NCH), .CNT_W(CNT_W), .HOLDOFF(HOLDOFF), .WINDOW(WINDOW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_ev (start_ev),
    .clr      (clr),
    .valid    (valid),
    .ts       (ts),
    .done     (done),
    .running  (running)
);

// File: tb/multistop_timer_tb.sv
module multistop_timer_tb;
    localparam int WIN  = 9400;
    localparam int HOLD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_in = 1'b0;
    logic [31:0] stop_in = 32'h0000_FF00;
    logic [6:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_rdata;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    multistop_timer u_dut (
        .clk(clk), .rst_n(rst_n), .start_in(start_in), .stop_in(stop_in),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata)
    );

    always #5 clk = ~clk;

    // behavioural reference model
    bit [32:0] h0, h1, h2;
    bit        m_spol, m_run, m_done;
    bit [31:0] m_en, m_pol, m_valid;
    int        m_ts[32];
    int        m_cnt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h0 = '0; h1 = '0; h2 = '0;
            m_spol = 0; m_run = 0; m_done = 0; m_en = '0; m_pol = '0; m_valid = '0; m_cnt = 0;
            foreach (m_ts[k]) m_ts[k] = 0;
        end else begin
            bit [32:0] pv, ev;
            bit clr_w;
            pv = {m_spol, m_pol};
            for (int k = 0; k < 33; k++)
                ev[k] = pv[k] ? (!h1[k] && h2[k]) : (h1[k] && !h2[k]);
            clr_w = bus_we && (bus_addr == 0) && bus_wdata[7];
            if (ev[32]) begin
                m_cnt = 0; m_run = 1; m_done = 0; m_valid = '0;
                foreach (m_ts[k]) m_ts[k] = 0;
            end else begin
                if (m_run) begin
                    for (int k = 0; k < 32; k++)
                        if (ev[k] && m_en[k] && !m_valid[k] && m_cnt >= HOLD) begin
                            m_valid[k] = 1; m_ts[k] = m_cnt;
                        end
                    if (m_cnt >= WIN - 1) begin m_cnt = WIN; m_run = 0; m_done = 1; end
                    else m_cnt++;
                end
                if (clr_w) begin
                    m_valid = '0; m_done = 0;
                    foreach (m_ts[k]) m_ts[k] = 0;
                end
            end
            if (bus_we) begin
                int a;
                a = int'(bus_addr);
                if (a == 0) m_spol = bus_wdata[0];
                if (a >= 1 && a <= 4) m_en[(a-1)*8 +: 8] = bus_wdata;
                if (a >= 5 && a <= 8) m_pol[(a-5)*8 +: 8] = bus_wdata;
            end
            h2 = h1; h1 = h0; h0 = {start_in, stop_in};
        end
    end

    function automatic bit [7:0] model_read(input int a);
        if (a == 0) return {7'b0, m_spol};
        if (a >= 1 && a <= 4) return m_en[(a-1)*8 +: 8];
        if (a >= 5 && a <= 8) return m_pol[(a-5)*8 +: 8];
        if (a >= 9 && a <= 12) return m_valid[(a-9)*8 +: 8];
        if (a == 13) return {6'b0, m_run, m_done};
        if (a >= 16 && a < 80) begin
            int ch;
            ch = (a - 16) / 2;
            return (a % 2 == 1) ? 8'(m_ts[ch] >> 8) : 8'(m_ts[ch]);
        end
        return 8'h00;
    endfunction

    function automatic string tag_of(input int a);
        if (a == 0) return "R2";
        if (a >= 1 && a <= 4) return "R6";
        if (a >= 5 && a <= 8) return "R7";
        if (a >= 9 && a <= 12) return "R5";
        if (a == 13) return "R8";
        if (a >= 16 && a < 80) return "R10";
        return "R1";
    endfunction

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit [7:0] e;
            e = model_read(int'(bus_addr));
            vectors++;
            if (bus_rdata !== e) begin
                miscompares++;
                $display("FAIL %s model addr %0d actual %h expected %h", tag_of(int'(bus_addr)), bus_addr, bus_rdata, e);
            end
        end
    end

    task automatic report();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input int a, input bit [7:0] d);
        bus_addr = 7'(a); bus_wdata = d; bus_we = 1'b1;
        step(1);
        bus_we = 1'b0;
    endtask

    task automatic chk(input string tag, input int a, input bit [7:0] e);
        bus_addr = 7'(a);
        @(negedge clk);
        vectors++;
        if (bus_rdata !== e) begin
            miscompares++;
            $display("FAIL %s addr %0d actual %h expected %h", tag, a, bus_rdata, e);
        end
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        // R1: everything reads zero after reset
        for (int a = 0; a < 80; a++) chk("R1", a, 8'h00);

        // R6/R7 configuration
        wr(1, 8'hFF); wr(2, 8'hFF); wr(3, 8'hFF); wr(4, 8'h0F);
        wr(6, 8'hFF);
        wr(13, 8'hFF); // R10: read-only write ignored
        chk("R10", 13, 8'h00);
        chk("R6", 4, 8'h0F);
        bus_addr = 7'd13;
        step(5);

        // measurement 1, rising start
        start_in = 1'b1;
        for (int t = 1; t <= 45; t++) begin
            step(1);
            case (t)
                2:  stop_in[0] = 1'b1;
                3:  start_in = 1'b0;
                4:  stop_in[2] = 1'b1;
                5:  stop_in[1] = 1'b1;
                6:  stop_in[0] = 1'b0;
                10: stop_in[0] = 1'b1;
                12: stop_in[28] = 1'b1;
                20: stop_in[3] = 1'b1;
                25: stop_in[3] = 1'b0;
                30: stop_in[3] = 1'b1;
                40: stop_in[15:8] = 8'h00;
                default: ;
            endcase
        end
        chk("R2", 13, 8'h02);
        step(9380);
        stop_in[5] = 1'b1;
        step(10);
        chk("R3", 16, 8'd9);
        chk("R4", 18, 8'd4);
        chk("R5", 22, 8'd19);
        chk("R7", 32, 8'd39);
        chk("R4", 9, 8'h0B);
        chk("R7", 10, 8'hFF);
        chk("R6", 12, 8'h00);
        chk("R8", 13, 8'h01);
        chk("R10", 17, 8'h00);

        // R9 clear command
        wr(0, 8'h80);
        chk("R9", 9, 8'h00);
        chk("R9", 16, 8'h00);
        chk("R9", 13, 8'h00);
        chk("R9", 0, 8'h00);

        // back to idle while not running: R8 no capture
        stop_in = 32'h0000_FF00;
        step(5);
        chk("R8", 9, 8'h00);

        // measurement 2, falling start, window boundaries
        wr(0, 8'h01);
        chk("R2", 0, 8'h01);
        bus_addr = 7'd13;
        start_in = 1'b1;
        step(6);
        chk("R2", 13, 8'h00);
        start_in = 1'b0;
        for (int t = 1; t <= 9405; t++) begin
            step(1);
            case (t)
                300:  stop_in[6] = 1'b1;
                9400: stop_in[7] = 1'b1;
                9401: stop_in[4] = 1'b1;
                default: ;
            endcase
        end
        step(5);
        chk("R10", 28, 8'h2B);
        chk("R10", 29, 8'h01);
        chk("R8", 30, 8'hB7);
        chk("R8", 31, 8'h24);
        chk("R8", 9, 8'hC0);
        chk("R8", 13, 8'h01);

        // measurement 3: clear while running, then retrigger
        stop_in[7:0] = 8'h00;
        bus_addr = 7'd13;
        step(5);
        start_in = 1'b1;
        step(3);
        start_in = 1'b0;
        step(20);
        stop_in[0] = 1'b1;
        step(10);
        chk("R3", 16, 8'd19);
        chk("R2", 13, 8'h02);
        wr(0, 8'h81);
        chk("R9", 9, 8'h00);
        chk("R9", 13, 8'h02);
        stop_in[1] = 1'b1;
        step(6);
        chk("R5", 9, 8'h02);
        start_in = 1'b1;
        step(3);
        start_in = 1'b0;
        step(5);
        chk("R2", 9, 8'h00);
        chk("R2", 13, 8'h02);
        step(2);
        report();
    end
endmodule